// File: doc/BRIEF.md
# Any-Direction Line Rasterizer

This block turns a pair of signed screen-space endpoints into the stream of pixel coordinates that make up a one-pixel-wide straight line between them, and tags each pixel with a colour. One core steps an integer error term. It only knows how to walk a shallow line in which the horizontal coordinate advances on every pixel and the vertical coordinate advances on some of them. Lines in any other direction are first mapped into that shallow case. Three tests make the mapping: the sign of the horizontal delta, the sign of the vertical delta, and which of the two deltas is larger in magnitude. Each pixel the core produces is then mapped back into the original direction before it leaves the block.

A request is offered on a valid/ready start handshake. Pixels come out on a valid/ready output handshake, so a downstream writer can stall the block at any pixel. After the last pixel has been taken, `done` pulses for one cycle and the block is ready for the next line. Address formation and clipping belong to the stages that follow.

Control is a five-state machine. The states are IDLE, SETUP, PLOT, STEP and DONE, and it moves through them as follows:
- IDLE goes to SETUP on an accepted start (the request is latched).
- SETUP goes to PLOT, after the error term has been initialised.
- PLOT holds while `out_ready` is low.
- PLOT goes to STEP when a pixel is taken and it is not the last one.
- PLOT goes to DONE when the last pixel is taken.
- STEP goes to PLOT after one coordinate and error update.
- DONE goes to IDLE.

Top module: `line_raster`

## Requirements
- R1: `start_ready` is 1 only in IDLE. A start is accepted when `start_valid` and `start_ready` are both 1 at a rising edge. A start offered while a line is in progress is ignored and changes nothing at the outputs.
- R2: A line covers both endpoints. It emits max(|x1-x0|, |y1-y0|) + 1 pixels. The first pixel is (x0, y0) and the last is (x1, y1).
- R3: A zero-length line (both endpoints equal) emits exactly one pixel, at that point, and then pulses `done`.
- R4: Stepping is done in folded space. The major coordinate advances by one on every pixel. The error term starts at 2·minor − major. When the error is positive before a step, the minor coordinate advances and the error changes by 2·minor − 2·major; otherwise the error grows by 2·minor. For example, (0,0)→(6,2) gives y = 0,0,1,1,1,2,2.
- R5: Lines in all eight octants are drawn. If |dy| > |dx|, y is the major axis. Each axis whose delta is negative is walked in the decreasing direction.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_x`, `out_y` and `out_colour` hold their values.
- R7: `done` is a one-cycle pulse. It is asserted in the cycle after the handshake of the last pixel, and never at any other time.
- R8: The colour is latched when the start is accepted. Every pixel of a line carries that colour, whatever `start_colour` does later.
- R9: After reset, `start_ready` is 1, and `out_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_valid | input | 1 | Line request offered |
| start_ready | output | 1 | Block idle, request can be taken |
| start_x0 | input | 16 | Start point x, signed |
| start_y0 | input | 16 | Start point y, signed |
| start_x1 | input | 16 | End point x, signed |
| start_y1 | input | 16 | End point y, signed |
| start_colour | input | 16 | Line colour |
| out_valid | output | 1 | Pixel presented |
| out_ready | input | 1 | Downstream takes the pixel |
| out_x | output | 16 | Pixel x, signed |
| out_y | output | 16 | Pixel y, signed |
| out_colour | output | 16 | Pixel colour |
| done | output | 1 | One-cycle end-of-line pulse |

## Verification
A wrong octant choice shows at once: the second pixel of the line moves in the wrong direction or along the wrong axis. A corrupted error term shows as a misplaced minor-axis step, at the first pixel that disagrees with the integer walk. A wrong end test shows as a missing or extra pixel just before `done`. The bench keeps a queue of expected pixels for each line, built by a behavioural walk. On every clock it compares each taken pixel, and it checks that `done` appears only once the queue is empty. This catches each of these faults within one pixel of where it happens, including while the output is randomly stalled.

// File: rtl/line_pkg.sv
package line_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PLOT,
        ST_STEP,
        ST_DONE
    } ras_state_t;

    typedef struct packed {
        logic swap;   // y is the major axis
        logic neg_x;  // walk x downward
        logic neg_y;  // walk y downward
    } octant_t;

endpackage

// File: rtl/line_fold.sv
module line_fold
    import line_pkg::*;
#(
    parameter int CW = 16,
    localparam int DW = CW + 1
) (
    input  logic signed [CW-1:0] x0,
    input  logic signed [CW-1:0] y0,
    input  logic signed [CW-1:0] x1,
    input  logic signed [CW-1:0] y1,
    output octant_t              oct,
    output logic [DW-1:0]        major,
    output logic [DW-1:0]        minor
);
    logic signed [DW-1:0] dx, dy;
    logic [DW-1:0]        adx, ady;

    always_comb begin
        dx  = DW'(x1) - DW'(x0);
        dy  = DW'(y1) - DW'(y0);
        adx = dx[DW-1] ? DW'(-dx) : DW'(dx);
        ady = dy[DW-1] ? DW'(-dy) : DW'(dy);
        oct.neg_x = dx[DW-1];
        oct.neg_y = dy[DW-1];
        oct.swap  = (ady > adx);
        major = oct.swap ? ady : adx;
        minor = oct.swap ? adx : ady;
    end
endmodule

// File: rtl/line_stepper.sv
module line_stepper #(
    parameter int DW = 17,
    localparam int EW = DW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init,
    input  logic          step,
    input  logic [DW-1:0] major,
    input  logic [DW-1:0] minor,
    output logic [DW-1:0] u,
    output logic [DW-1:0] v,
    output logic          last
);
    logic signed [EW-1:0] err;
    logic signed [EW-1:0] tmin, tmaj;

    assign tmin = signed'({1'b0, minor, 1'b0});
    assign tmaj = signed'({1'b0, major, 1'b0});
    assign last = (u == major);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            u   <= '0;
            v   <= '0;
            err <= '0;
        end else if (init) begin
            u   <= '0;
            v   <= '0;
            err <= tmin - signed'({2'b00, major});
        end else if (step) begin
            u <= u + 1'b1;
            if (err > 0) begin
                v   <= v + 1'b1;
                err <= err + tmin - tmaj;
            end else begin
                err <= err + tmin;
            end
        end
    end

    AST_ERR_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (err >= -tmaj) && (err <= tmin)); // R4

    AST_MAJOR_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (u == $past(u) + 1'b1)); // R4
endmodule

// File: rtl/line_unfold.sv
module line_unfold
    import line_pkg::*;
#(
    parameter int CW = 16,
    localparam int DW = CW + 1
) (
    input  logic signed [CW-1:0] x0,
    input  logic signed [CW-1:0] y0,
    input  octant_t              oct,
    input  logic [DW-1:0]        u,
    input  logic [DW-1:0]        v,
    output logic signed [CW-1:0] px,
    output logic signed [CW-1:0] py
);
    logic signed [DW-1:0] ax, ay, sx, sy;

    always_comb begin
        ax = signed'(oct.swap ? v : u);
        ay = signed'(oct.swap ? u : v);
        sx = DW'(x0) + (oct.neg_x ? -ax : ax);
        sy = DW'(y0) + (oct.neg_y ? -ay : ay);
        px = sx[CW-1:0];
        py = sy[CW-1:0];
    end
endmodule

// File: rtl/line_raster.sv
module line_raster
    import line_pkg::*;
#(
    parameter int CW  = 16,
    parameter int CLW = 16,
    localparam int DW = CW + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_valid,
    output logic                  start_ready,
    input  logic signed [CW-1:0]  start_x0,
    input  logic signed [CW-1:0]  start_y0,
    input  logic signed [CW-1:0]  start_x1,
    input  logic signed [CW-1:0]  start_y1,
    input  logic [CLW-1:0]        start_colour,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic signed [CW-1:0]  out_x,
    output logic signed [CW-1:0]  out_y,
    output logic [CLW-1:0]        out_colour,
    output logic                  done
);
    ras_state_t state, state_nx;

    logic signed [CW-1:0] x0_q, y0_q, x1_q, y1_q;
    logic [CLW-1:0]       col_q;
    octant_t              oct;
    logic [DW-1:0]        major, minor, u, v;
    logic                 last, do_init, do_step, accept;

    assign accept = start_valid && (state == ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x0_q  <= '0;
            y0_q  <= '0;
            x1_q  <= '0;
            y1_q  <= '0;
            col_q <= '0;
        end else if (accept) begin
            x0_q  <= start_x0;
            y0_q  <= start_y0;
            x1_q  <= start_x1;
            y1_q  <= start_y1;
            col_q <= start_colour;
        end
    end

    line_fold #(.CW(CW)) u_fold (
        .x0(x0_q), .y0(y0_q), .x1(x1_q), .y1(y1_q),
        .oct(oct), .major(major), .minor(minor)
    );

    line_stepper #(.DW(DW)) u_step (
        .clk(clk), .rst_n(rst_n), .init(do_init), .step(do_step),
        .major(major), .minor(minor), .u(u), .v(v), .last(last)
    );

    line_unfold #(.CW(CW)) u_unfold (
        .x0(x0_q), .y0(y0_q), .oct(oct), .u(u), .v(v),
        .px(out_x), .py(out_y)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start_valid) state_nx = ST_SETUP;
            ST_SETUP: state_nx = ST_PLOT;
            ST_PLOT:  if (out_ready) state_nx = last ? ST_DONE : ST_STEP;
            ST_STEP:  state_nx = ST_PLOT;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        start_ready = 1'b0;
        out_valid   = 1'b0;
        done        = 1'b0;
        do_init     = 1'b0;
        do_step     = 1'b0;
        unique case (state)
            ST_IDLE:  start_ready = 1'b1;
            ST_SETUP: do_init     = 1'b1;
            ST_PLOT:  out_valid   = 1'b1;
            ST_STEP:  do_step     = 1'b1;
            ST_DONE:  done        = 1'b1;
            default:  ;
        endcase
    end

    assign out_colour = col_q;

    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_ready |-> !out_valid && !done); // R1

    AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_x)
            && $stable(out_y) && $stable(out_colour)); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_DONE_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(out_valid && out_ready)); // R7
endmodule

// File: tb/line_raster_test.sv
module line_raster_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_valid = 1'b0;
    logic start_ready;
    logic signed [15:0] sx0 = '0, sy0 = '0, sx1 = '0, sy1 = '0;
    logic [15:0] scol = '0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic signed [15:0] out_x, out_y;
    logic [15:0] out_colour;
    logic done;

    int checks = 0;
    int fails = 0;
    bit rand_ready = 0;
    bit finished = 0;
    logic [47:0] exp_q[$];

    always #2 clk = ~clk;

    line_raster uut (
        .clk(clk), .rst_n(rst_n),
        .start_valid(start_valid), .start_ready(start_ready),
        .start_x0(sx0), .start_y0(sy0), .start_x1(sx1), .start_y1(sy1),
        .start_colour(scol),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_x(out_x), .out_y(out_y), .out_colour(out_colour),
        .done(done)
    );

    task automatic check(input bit ok, input string req,
                         input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural integer walk of the line (R2, R4, R5)
    task automatic build(input int x0, input int y0, input int x1, input int y1,
                         input logic [15:0] col);
        int dx = x1 - x0, dy = y1 - y0;
        int ax = dx < 0 ? -dx : dx;
        int ay = dy < 0 ? -dy : dy;
        int stx = dx < 0 ? -1 : 1;
        int sty = dy < 0 ? -1 : 1;
        bit steep = ay > ax;
        int mj = steep ? ay : ax;
        int mn = steep ? ax : ay;
        int e = 2 * mn - mj;
        int b = 0;
        for (int a = 0; a <= mj; a++) begin
            int px = x0 + stx * (steep ? b : a);
            int py = y0 + sty * (steep ? a : b);
            exp_q.push_back({px[15:0], py[15:0], col});
            if (e > 0) begin
                b++;
                e -= 2 * mj;
            end
            e += 2 * mn;
        end
    endtask

    // Per-clock comparison against the expected queue
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0)
                check(0, "R2 extra pixel", {out_x, out_y, out_colour}, '0);
            else begin
                logic [47:0] e;
                e = exp_q.pop_front();
                check({out_x, out_y, out_colour} == e, "R2/R4/R5/R8 pixel",
                      {out_x, out_y, out_colour}, e);
            end
        end
        if (rst_n && done)
            check(exp_q.size() == 0, "R7/R3 done with pixels left",
                  48'(exp_q.size()), 0);
    end

    always @(posedge clk) begin
        #1 out_ready = rand_ready ? ($urandom % 4 != 0) : 1'b1;
    end

    task automatic draw(input int x0, input int y0, input int x1, input int y1,
                        input logic [15:0] col, input bit poke);
        int guard = 0;
        build(x0, y0, x1, y1, col);
        @(posedge clk); #1;
        sx0 = 16'(x0); sy0 = 16'(y0); sx1 = 16'(x1); sy1 = 16'(y1);
        scol = col; start_valid = 1'b1;
        @(posedge clk); #1;
        start_valid = 1'b0;
        scol = ~col;                       // R8: later colour changes ignored
        if (poke) begin
            // R1: request offered while busy must be ignored
            sx0 = 16'sd100; sy0 = -16'sd50; sx1 = 16'sd7; sy1 = 16'sd7;
            start_valid = 1'b1;
            @(negedge clk);
            check(start_ready == 1'b0, "R1 ready while busy", 48'(start_ready), 0);
            @(posedge clk); #1;
            start_valid = 1'b0;
        end
        while (!done && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        check(done == 1'b1, "R7 done seen", 48'(done), 1);
        @(negedge clk);
        check(done == 1'b0 && start_ready == 1'b1, "R7 done single / R1 idle",
              {46'd0, done, start_ready}, 48'd1);
        check(exp_q.size() == 0, "R2 all pixels drawn", 48'(exp_q.size()), 0);
        exp_q.delete();
    endtask

    initial begin
        #100000;
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(start_ready == 1'b1 && out_valid == 1'b0 && done == 1'b0,
              "R9 reset state", {45'd0, start_ready, out_valid, done}, 48'b100);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);

        draw(0, 0, 6, 2, 16'h0F0F, 0);          // R4 three-to-one slope
        draw(5, -3, 5, -3, 16'h1234, 0);        // R3 zero length
        draw(2, 3, -1, 10, 16'h00AA, 0);        // R5 steep, x reversed
        draw(-4, 8, -12, 8, 16'hBEEF, 0);       // R5 horizontal, reversed
        draw(0, 0, -5, -5, 16'h5555, 0);        // R5 diagonal
        for (int k = 0; k < 8; k++) begin       // R5 all eight octants
            int ex = (k % 2 == 0) ? 9 : 4;
            int ey = (k % 2 == 0) ? 4 : 9;
            if (k >= 2 && k < 6) ex = -ex;
            if (k >= 4) ey = -ey;
            draw(1, -2, 1 + ex, -2 + ey, 16'(k + 1), 0);
        end
        rand_ready = 1;                         // R6 stalls under backpressure
        draw(-300, -200, 400, 100, 16'hCAFE, 0);
        draw(10, 10, 13, 40, 16'hD00D, 1);      // R1 busy start ignored, R8
        draw(0, 0, 0, 0, 16'h7777, 0);          // R3 with stalls
        rand_ready = 0;
        draw(32000, -32000, 31990, -31970, 16'hABCD, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule